// File: doc/BRIEF.md
# Line-rate horizontal and back-porch pulse generator

This block takes a composite sync signal that is already digital and synchronised to the local clock. It turns that signal into two clean timing strobes. A horizontal strobe of fixed width starts on each valid sync leading edge. A back-porch gate starts on each sync trailing edge. Downstream logic uses the horizontal strobe as its line reference and the back-porch gate to sample or clamp the black level.

During vertical blanking, composite sync carries equalising and serration pulses at twice the line rate. Each accepted horizontal strobe opens a lockout window of about three quarters of a line. Leading edges inside that window are dropped, so only one strobe per line reaches the output. Every duration is given in tenths of a microsecond and scaled by a single clocks-per-microsecond setting, so all of them track one scan-rate choice.

Top module: `hbp_pulse_gen`

## Requirements
- R1: Synchronous active-high reset forces `h_pulse` and `bp_pulse` low and clears the lockout window. The first leading edge after reset is accepted.
- R2: Sync is active high, and a leading edge is a 0-to-1 change of `csync_in` between two clock edges. An accepted leading edge sampled at clock edge k raises `h_pulse` from clock edge k onward. The register is cleared at reset, so a `csync_in` already high at the first sampled edge after reset counts as a leading edge.
- R3: `h_pulse` stays high for exactly H_CYC = CLK_PER_US*H_TENTHS_US/10 cycles.
- R4: After an edge is accepted at clock edge k, leading edges sampled at edges k+1 through k+LOCK_CYC produce no horizontal strobe. LOCK_CYC = LINE_CYC*LOCK_PCT/100. A leading edge at k+LOCK_CYC+1 or later is accepted, so edges spaced half a line apart are removed.
- R5: A leading edge that arrives while `h_pulse` is high neither restarts nor stretches it.
- R6: A trailing edge is a 1-to-0 change of `csync_in`. When one is sampled at clock edge k while `bp_pulse` is low, `bp_pulse` goes high from edge k for exactly BP_CYC = CLK_PER_US*BP_TENTHS_US/10 cycles.
- R7: A trailing edge that arrives while `bp_pulse` is high is ignored. The pulse ends on its original schedule.
- R8: All durations come from CLK_PER_US and the tenth-of-a-microsecond parameters, so changing CLK_PER_US scales every pulse and window together.
- R9: The back-porch gate does not depend on the lockout. A trailing edge inside the lockout window still starts `bp_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csync_in | input | 1 | Synchronised composite sync, high during the sync tip |
| h_pulse | output | 1 | Registered horizontal strobe |
| bp_pulse | output | 1 | Registered back-porch gate |

## Verification
Each kind of corrupted internal state shows up at the ports in its own way:
- A lockout counter that is off by one moves the accept/reject boundary by one cycle. Edges placed exactly LOCK_CYC and LOCK_CYC+1 after an accepted edge expose this on the next strobe.
- A one-shot counter that is wrong shows as a strobe edge that is early or late by a cycle, within one pulse width.
- A missing busy guard shows as a restarted back-porch gate within BP_CYC cycles of a second trailing edge.
- An edge register that does not clear shows as a missing strobe on the first line after reset.

The bench compares every output on every cycle, so any of these differences is reported in the cycle it appears.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  // cycles for a duration given in tenths of a microsecond
  function automatic int unsigned tenths_to_cyc(input int unsigned clk_per_us,
                                                input int unsigned tenths);
    int unsigned c;
    c = (clk_per_us * tenths) / 10;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/hbp_edge_det.sv
module hbp_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  output logic lead,
  output logic trail
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_in;
  end

  assign lead  = sync_in & ~prev_q;
  assign trail = ~sync_in & prev_q;
endmodule

// File: rtl/hbp_oneshot.sv
module hbp_oneshot #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic active
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LOAD = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (!active) begin
      if (trig) begin
        active <= 1'b1;
        cnt_q  <= LOAD;
      end
    end else if (cnt_q == '0) begin
      active <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3 / R6: a running one-shot terminates when its count is spent
  a_r3_oneshot_ends: assert property (@(posedge clk) disable iff (rst)
    active && (cnt_q == '0) |=> !active);

  // R5 / R7: a trigger while running neither reloads nor stalls the count
  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    active && trig && (cnt_q != '0) |=> active && (cnt_q == $past(cnt_q) - 1'b1));

  // R1: out of reset the one-shot is idle
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !active);
endmodule

// File: rtl/hbp_pulse_gen.sv
module hbp_pulse_gen #(
  parameter int unsigned CLK_PER_US     = 100,
  parameter int unsigned H_TENTHS_US    = 50,
  parameter int unsigned BP_TENTHS_US   = 25,
  parameter int unsigned LINE_TENTHS_US = 640,
  parameter int unsigned LOCK_PCT       = 75
) (
  input  logic clk,
  input  logic rst,
  input  logic csync_in,
  output logic h_pulse,
  output logic bp_pulse
);
  import hbp_pkg::*;

  // R8: every duration derives from the one clock-rate setting
  localparam int unsigned H_CYC    = tenths_to_cyc(CLK_PER_US, H_TENTHS_US);
  localparam int unsigned BP_CYC   = tenths_to_cyc(CLK_PER_US, BP_TENTHS_US);
  localparam int unsigned LINE_CYC = tenths_to_cyc(CLK_PER_US, LINE_TENTHS_US);
  localparam int unsigned LOCK_RAW = (LINE_CYC * LOCK_PCT) / 100;
  localparam int unsigned LOCK_CYC = (LOCK_RAW > H_CYC) ? LOCK_RAW : H_CYC;

  logic lead, trail, lock_on, accept;

  hbp_edge_det edge_i (
    .clk(clk), .rst(rst), .sync_in(csync_in), .lead(lead), .trail(trail)
  );

  // half-line eliminator: only edges outside the lockout window pass
  assign accept = lead & ~lock_on;

  hbp_oneshot #(.LEN(LOCK_CYC)) lock_i (
    .clk(clk), .rst(rst), .trig(accept), .active(lock_on)
  );

  hbp_oneshot #(.LEN(H_CYC)) hos_i (
    .clk(clk), .rst(rst), .trig(accept), .active(h_pulse)
  );

  // R9: back porch is driven by trailing edges alone
  hbp_oneshot #(.LEN(BP_CYC)) bpos_i (
    .clk(clk), .rst(rst), .trig(trail), .active(bp_pulse)
  );

  // R2: a horizontal strobe only starts from a sensed leading edge
  a_r2_h_from_lead: assert property (@(posedge clk) disable iff (rst)
    $rose(h_pulse) |-> $past(lead));

  // R4: the strobe always lies inside its own lockout window
  a_r4_h_within_lock: assert property (@(posedge clk) disable iff (rst)
    h_pulse |-> lock_on);

  // R4: an edge seen during lockout starts no strobe
  a_r4_locked_edge_dropped: assert property (@(posedge clk) disable iff (rst)
    lead && lock_on |=> !$rose(h_pulse));

  // R6: a back-porch gate only starts from a sensed trailing edge
  a_r6_bp_from_trail: assert property (@(posedge clk) disable iff (rst)
    $rose(bp_pulse) |-> $past(trail));
endmodule

// File: tb/hbp_pulse_gen_tb.sv
module hbp_pulse_gen_tb_top;
  localparam int CPU  = 10;
  localparam int H    = CPU * 50 / 10;    // 50
  localparam int BP   = CPU * 25 / 10;    // 25
  localparam int LINE = CPU * 640 / 10;   // 640
  localparam int LOCK = LINE * 75 / 100;  // 480

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csync = 1'b0;
  logic h_pulse, bp_pulse;

  always #5 clk = ~clk;

  hbp_pulse_gen #(.CLK_PER_US(CPU)) dut_i (
    .clk(clk), .rst(rst), .csync_in(csync), .h_pulse(h_pulse), .bp_pulse(bp_pulse)
  );

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model, written from the requirements
  bit m_prev = 1'b0;
  int h_rem = 0, lock_rem = 0, bp_rem = 0;
  bit exp_h = 1'b0, exp_bp = 1'b0;

  function automatic bit accept_edge(input bit lead, input int lrem);
    return lead && (lrem == 0);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_prev = 1'b0; h_rem = 0; lock_rem = 0; bp_rem = 0;
    end else begin
      bit lead, trail;
      lead  = csync && !m_prev;
      trail = !csync && m_prev;
      m_prev = csync;
      if (accept_edge(lead, lock_rem)) begin
        h_rem = H; lock_rem = LOCK;
      end else begin
        if (h_rem > 0) h_rem--;
        if (lock_rem > 0) lock_rem--;
      end
      if (trail && bp_rem == 0) bp_rem = BP;
      else if (bp_rem > 0) bp_rem--;
    end
    exp_h  = (h_rem > 0);
    exp_bp = (bp_rem > 0);
  end

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (h_pulse !== exp_h) begin
        fails++;
        $display("FAIL %s h_pulse actual=%b expected=%b at cycle %0d", tag, h_pulse, exp_h, cycles);
      end
      if (bp_pulse !== exp_bp) begin
        fails++;
        $display("FAIL %s bp_pulse actual=%b expected=%b at cycle %0d", tag, bp_pulse, exp_bp, cycles);
      end
      if (cycles > 190000) begin
        fails++;
        done = 1'b1;
        $display("FAIL watchdog actual=%0d cycles expected<190000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  task automatic seg(input bit v, input int n);
    csync = v;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    // R1: outputs low while in reset
    tag = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    seg(0, 10);
    // R1: first edge after reset accepted; R2 R3 R6: normal lines
    tag = "R2 R3 R6 R8";
    for (int i = 0; i < 8; i++) begin seg(1, 47); seg(0, LINE - 47); end
    // R4: equalising and serration pulses at half-line spacing
    tag = "R4 R9";
    for (int i = 0; i < 12; i++) begin seg(1, 23); seg(0, LINE/2 - 23); end
    for (int i = 0; i < 12; i++) begin seg(1, LINE/2 - 48); seg(0, 48); end
    for (int i = 0; i < 6; i++) begin seg(1, 47); seg(0, LINE - 47); end
    // R4: boundary, next edge exactly LOCK then LOCK+1 after accepted edge
    tag = "R4";
    seg(1, 10); seg(0, LOCK - 10);
    seg(1, 10); seg(0, LINE);
    seg(1, 10); seg(0, LOCK + 1 - 10);
    seg(1, 10); seg(0, LINE);
    // R5: leading edges during an active strobe
    tag = "R5";
    seg(1, 5); seg(0, 10); seg(1, 5); seg(0, 10); seg(1, 5); seg(0, LINE);
    // R7: trailing edges during an active back-porch gate
    tag = "R7";
    seg(1, 3); seg(0, 4); seg(1, 3); seg(0, 6); seg(1, 2); seg(0, BP - 1);
    seg(1, 2); seg(0, LINE);
    // random pulse trains
    tag = "R2 R4 R5 R6 R7";
    for (int i = 0; i < 60; i++) begin
      seg(1, 1 + int'($urandom_range(60)));
      seg(0, 1 + int'($urandom_range(700)));
    end
    // R1: reset mid-pulse clears outputs and lockout
    tag = "R1";
    seg(1, 5);
    rst = 1'b1; repeat (3) @(negedge clk);
    csync = 1'b0; rst = 1'b0;
    seg(0, 5); seg(1, 20); seg(0, LINE);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule